// File: doc/BRIEF.md
# Parallel Eight-Tap FIR Multiply-Accumulate Unit

This block computes one finite-impulse-response filter output per clock cycle. It holds a chain of eight sample registers and a bank of eight coefficient registers. Every cycle it multiplies each stored sample by its coefficient, using eight multipliers at once, and adds the products in a balanced adder tree. The sum is captured in a result register.

Software writes a coefficient into one slot at a time. A start pulse arms the unit. Samples then enter the chain on a valid strobe. Once the chain holds eight samples that arrived since the last arm, the unit produces a result on every cycle, whether or not a new sample arrives. A halt input stops the filtering at once and empties the fill count, so the next run must refill the whole chain. A mode input reduces the filter to the four newest taps by forcing zero into the upper four multipliers.

Top module: `fir8_mac`

## Requirements
- R1: While reset is held and right after it, `result` is zero and `result_valid` is low.
- R2: When `coef_wr` is high at a clock edge, the low 16 bits of `coef_in` are stored as an unsigned value in the slot given by `coef_sel`, and the upper 16 bits are ignored. Slot k multiplies delay-line position k, and position 0 is the newest sample. The new value is used from the following cycle.
- R3: A sample is kept as its low 16 bits with bit 15 inverted (two's complement turned into offset binary, so stored = `sample_in[15:0] ^ 16'h8000`). Bits 31..16 are ignored.
- R4: A sample is accepted when `sample_valid` is high while the unit is armed and `halt` is low. The sample enters position 0, every other position moves up by one, and the sample in position 7 is dropped. Samples offered while the unit is not armed change nothing.
- R5: No result is produced until eight samples have been accepted since the last arm. Halt clears this count.
- R6: The result is the sum over the active taps of coefficient times stored sample, formed from the chain and coefficient contents as they stand during a cycle. It appears with `result_valid` high after the next clock edge.
- R7: When `four_tap` is high, taps 4 to 7 add nothing to the result.
- R8: While the unit is armed, the chain is full and `halt` is low, `result_valid` is high on every cycle, even when no new sample arrives.
- R9: `start` arms the unit. `halt` disarms it, and halt wins when both are high together. A halt seen at an edge stops any result from that edge on.
- R10: The sum wraps modulo 2^32 and never saturates.
- R11: While `result_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sample_valid | input | 1 | New sample strobe |
| sample_in | input | 32 | Signed sample; only the low 16 bits are used |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient slot to write |
| coef_in | input | 32 | Coefficient value; only the low 16 bits are used |
| four_tap | input | 1 | 1 selects four taps, 0 selects eight taps |
| start | input | 1 | Arm pulse |
| halt | input | 1 | Stop filtering and clear the fill count |
| result | output | 32 | Filter output |
| result_valid | output | 1 | High for each cycle that carries a computed output |

## Verification
Distinct coefficients 1 to 8 are used against distinct samples, so that a swapped tap, a missing shift or an off-by-one cycle gives a different sum. Samples with negative, boundary and junk-upper-half values show apart a wrong signed-to-offset conversion and a leak of unused bits. All-ones operands expose any saturation or width loss in the adder tree. Samples offered after a halt without a fresh arm, followed by a refill, show whether ignored inputs leak into the chain or the fill count, and the four-tap mode is set while the upper taps hold nonzero data.

// File: rtl/fir8_pkg.sv
package fir8_pkg;

  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

  // Offset-binary view of a two's-complement value of width w (MSB inverted).
  function automatic logic [15:0] to_offset16(input logic [15:0] v);
    return v ^ 16'h8000;
  endfunction

endpackage

// File: rtl/fir8_ctrl.sv
module fir8_ctrl
  import fir8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic halt_i,
  input  logic smp_vld_i,
  input  logic full_i,
  output logic run_o,
  output logic accept_o,
  output logic emit_o,
  output logic clear_o
);

  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (halt_i)       state_d = RUN_IDLE;
    else if (start_i) state_d = RUN_ACTIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RUN_IDLE;
    else        state_q <= state_d;
  end

  assign run_o    = (state_q == RUN_ACTIVE);
  assign accept_o = run_o && smp_vld_i && !halt_i;
  assign emit_o   = run_o && full_i && !halt_i;
  assign clear_o  = halt_i;

endmodule

// File: rtl/fir8_delay_line.sv
module fir8_delay_line #(
  parameter int TAPS = 8,
  parameter int MW   = 16,
  localparam int CW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic          clear_i,
  input  logic [MW-1:0] din_i,
  output logic [MW-1:0] taps_o [TAPS],
  output logic [CW-1:0] fill_o,
  output logic          full_o
);

  logic [MW-1:0] line_q [TAPS];
  logic [MW-1:0] line_d [TAPS];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;

  always_comb begin
    for (int i = 0; i < TAPS; i++) line_d[i] = line_q[i];
    if (shift_i) begin
      line_d[0] = din_i;
      for (int i = 1; i < TAPS; i++) line_d[i] = line_q[i-1];
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (clear_i) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (shift_i && !full_q) begin
      if (cnt_q == CW'(TAPS-1)) full_d = 1'b1;
      else                      cnt_d  = cnt_q + 1'b1;
    end
  end

  // Data registers: no reset needed, enable-gated shift.
  always_ff @(posedge clk) begin
    for (int i = 0; i < TAPS; i++) line_q[i] <= line_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  assign taps_o = line_q;
  assign fill_o = cnt_q;
  assign full_o = full_q;

endmodule

// File: rtl/fir8_coef_bank.sv
module fir8_coef_bank #(
  parameter int TAPS = 8,
  parameter int MW   = 16,
  localparam int AW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] sel_i,
  input  logic [MW-1:0] din_i,
  output logic [MW-1:0] coef_o [TAPS]
);

  logic [MW-1:0] coef_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_slot
    logic          hit;
    logic [MW-1:0] slot_d;
    assign hit    = wr_i && (sel_i == AW'(g));
    assign slot_d = hit ? din_i : coef_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[g] <= '0;
      else        coef_q[g] <= slot_d;
    end
  end

  assign coef_o = coef_q;

endmodule

// File: rtl/fir8_dot.sv
module fir8_dot #(
  parameter int TAPS = 8,
  parameter int MW   = 16,
  parameter int DW   = 32,
  localparam int LVLS = $clog2(TAPS)
) (
  input  logic [MW-1:0] smp_i  [TAPS],
  input  logic [MW-1:0] coef_i [TAPS],
  input  logic          half_i,
  output logic [DW-1:0] sum_o
);

  logic [DW-1:0] prod [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    logic [MW-1:0] op_s;
    if (g >= TAPS/2) begin : g_upper
      assign op_s = half_i ? '0 : smp_i[g];
    end else begin : g_lower
      assign op_s = smp_i[g];
    end
    assign prod[g] = DW'(op_s) * DW'(coef_i[g]);
  end

  // Balanced reduction, wraps modulo 2^DW.
  always_comb begin
    logic [DW-1:0] node [TAPS];
    for (int i = 0; i < TAPS; i++) node[i] = prod[i];
    for (int l = 0; l < LVLS; l++) begin
      for (int i = 0; i < (TAPS >> (l + 1)); i++) begin
        node[i] = node[2*i] + node[2*i+1];
      end
    end
    sum_o = node[0];
  end

endmodule

// File: rtl/fir8_mac.sv
module fir8_mac #(
  parameter int TAPS = 8,
  parameter int MW   = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(TAPS),
  localparam int CW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample_in,
  input  logic          coef_wr,
  input  logic [AW-1:0] coef_sel,
  input  logic [DW-1:0] coef_in,
  input  logic          four_tap,
  input  logic          start,
  input  logic          halt,
  output logic [DW-1:0] result,
  output logic          result_valid
);
  import fir8_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [DW-MW-1:0] unused_smp_hi;
  logic [DW-MW-1:0] unused_coef_hi;
  assign unused_smp_hi  = sample_in[DW-1:MW];
  assign unused_coef_hi = coef_in[DW-1:MW];

  logic [MW-1:0] smp_conv;
  assign smp_conv = to_offset16(sample_in[MW-1:0]);

  logic          run_q, accept, emit, clear;
  logic          line_full;
  logic [CW-1:0] line_fill;
  logic [MW-1:0] line_taps [TAPS];
  logic [MW-1:0] coefs     [TAPS];
  logic [DW-1:0] dot_sum;

  fir8_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_i   (start),
    .halt_i    (halt),
    .smp_vld_i (sample_valid),
    .full_i    (line_full),
    .run_o     (run_q),
    .accept_o  (accept),
    .emit_o    (emit),
    .clear_o   (clear)
  );

  fir8_delay_line #(.TAPS(TAPS), .MW(MW)) u_line (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .shift_i (accept),
    .clear_i (clear),
    .din_i   (smp_conv),
    .taps_o  (line_taps),
    .fill_o  (line_fill),
    .full_o  (line_full)
  );

  fir8_coef_bank #(.TAPS(TAPS), .MW(MW)) u_coef (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_i   (coef_wr),
    .sel_i  (coef_sel),
    .din_i  (coef_in[MW-1:0]),
    .coef_o (coefs)
  );

  fir8_dot #(.TAPS(TAPS), .MW(MW), .DW(DW)) u_dot (
    .smp_i  (line_taps),
    .coef_i (coefs),
    .half_i (four_tap),
    .sum_o  (dot_sum)
  );

  logic [DW-1:0] res_q, res_d;
  logic          vld_q;

  assign res_d = emit ? dot_sum : res_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= emit;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;

endmodule

// File: rtl/fir8_mac_chk.sv
module fir8_mac_chk #(
  parameter int DW = 32,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt,
  input logic          run,
  input logic          full,
  input logic [CW-1:0] fill,
  input logic [DW-1:0] result,
  input logic          result_valid
);

  assert_halt_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !result_valid);

  assert_halt_clears_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (fill == '0 && !full));

  assert_valid_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(full));

  assert_continuous_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && full && !halt) |=> result_valid);

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  assert_idle_no_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(fill));

endmodule

bind fir8_mac fir8_mac_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .halt         (halt),
  .run          (run_q),
  .full         (line_full),
  .fill         (line_fill),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/sim_fir8_mac.sv
`timescale 1ns/1ps
module sim_fir8_mac;

  logic        clk;
  logic        rst_n;
  logic        sample_valid;
  logic [31:0] sample_in;
  logic        coef_wr;
  logic [2:0]  coef_sel;
  logic [31:0] coef_in;
  logic        four_tap;
  logic        start;
  logic        halt;
  logic [31:0] result;
  logic        result_valid;

  int n_tests;
  int n_fail;

  logic [31:0] m_s [8];
  logic [31:0] m_c [8];

  fir8_mac u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
    .coef_wr(coef_wr), .coef_sel(coef_sel), .coef_in(coef_in), .four_tap(four_tap),
    .start(start), .halt(halt), .result(result), .result_valid(result_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] expect_sum();
    logic [31:0] acc = 32'h0;
    for (int i = 0; i < (four_tap ? 4 : 8); i++) acc = acc + m_c[i] * m_s[i];
    return acc;
  endfunction

  task automatic load_coef(input int idx, input logic [31:0] v);
    coef_wr = 1'b1; coef_sel = 3'(idx); coef_in = v;
    step();
    coef_wr = 1'b0;
    m_c[idx] = {16'h0, v[15:0]};
  endtask

  task automatic push(input logic [31:0] s, input logic accepted);
    sample_valid = 1'b1; sample_in = s;
    step();
    sample_valid = 1'b0;
    if (accepted) begin
      for (int i = 7; i > 0; i--) m_s[i] = m_s[i-1];
      m_s[0] = {16'h0, s[15:0] ^ 16'h8000};
    end
  endtask

  task automatic arm();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sample_valid = 0; sample_in = 0; coef_wr = 0; coef_sel = 0;
    coef_in = 0; four_tap = 0; start = 0; halt = 0;
    for (int i = 0; i < 8; i++) begin m_s[i] = 0; m_c[i] = 0; end
    repeat (3) step();
    check("R1 result in reset", result, 32'h0);
    check("R1 valid in reset", {31'h0, result_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1 valid after reset", {31'h0, result_valid}, 32'h0);
  endtask

  task automatic t_fill_and_compute();
    for (int i = 0; i < 8; i++) load_coef(i, 32'(i + 1));
    arm();
    for (int i = 0; i < 7; i++) begin
      push(32'(i * 100 - 300), 1'b1);
      check("R5 no output before full", {31'h0, result_valid}, 32'h0);
    end
    repeat (3) step();
    check("R5 no output with seven samples", {31'h0, result_valid}, 32'h0);
    push(32'h0000_0123, 1'b1);
    check("R5 eighth sample edge", {31'h0, result_valid}, 32'h0);
    step();
    check("R6 first valid", {31'h0, result_valid}, 32'h1);
    check("R6 first result", result, expect_sum());
  endtask

  task automatic t_continuous();
    logic [31:0] prev;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 valid every cycle", {31'h0, result_valid}, 32'h1);
      check("R8 steady result", result, expect_sum());
    end
    prev = expect_sum();
    push(32'hFFFF_FF80, 1'b1);
    check("R4 result during shift edge uses old line", result, prev);
    step();
    check("R4 result after shift", result, expect_sum());
  endtask

  task automatic t_coef_update();
    load_coef(7, 32'hDEAD_0040);
    step();
    check("R2 new coefficient used, upper bits ignored", result, expect_sum());
  endtask

  task automatic t_half_mode();
    logic [31:0] full8;
    full8 = expect_sum();
    four_tap = 1'b1;
    step();
    check("R7 four-tap result", result, expect_sum());
    if (expect_sum() == full8) check("R7 modes must differ", 32'h0, 32'h1);
    four_tap = 1'b0;
    step();
    check("R7 back to eight taps", result, expect_sum());
  endtask

  task automatic t_convert();
    push(32'hABCD_8000, 1'b1);
    push(32'h0000_7FFF, 1'b1);
    push(32'hFFFF_FFFF, 1'b1);
    push(32'h5555_0000, 1'b1);
    step();
    check("R3 offset-binary samples", result, expect_sum());
    check("R3 newest stored as 0x8000 slot", m_s[0], 32'h0000_8000);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) load_coef(i, 32'h0000_FFFF);
    for (int i = 0; i < 8; i++) push(32'h0000_7FFF, 1'b1);
    step();
    check("R10 wrapped sum", result, 32'hFFF0_0008);
  endtask

  task automatic t_halt_restart();
    logic [31:0] last;
    for (int i = 0; i < 8; i++) load_coef(i, 32'(3 * i + 2));
    step();
    last = result;
    halt = 1'b1; start = 1'b1;
    step();
    halt = 1'b0; start = 1'b0;
    check("R9 halt stops output", {31'h0, result_valid}, 32'h0);
    check("R11 result held after halt", result, last);
    for (int i = 0; i < 4; i++) push(32'h0000_4444, 1'b0);
    repeat (2) step();
    check("R9 idle stays silent", {31'h0, result_valid}, 32'h0);
    check("R11 result held while idle", result, last);
    arm();
    for (int i = 0; i < 7; i++) push(32'(i * 7 + 1), 1'b1);
    step();
    check("R5 refill needed after halt", {31'h0, result_valid}, 32'h0);
    push(32'h0000_0200, 1'b1);
    step();
    check("R4 ignored samples absent after restart", result, expect_sum());
    check("R9 valid after restart", {31'h0, result_valid}, 32'h1);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    t_reset();
    t_fill_and_compute();
    t_continuous();
    t_coef_update();
    t_half_mode();
    t_convert();
    t_wrap();
    t_halt_restart();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule